// File: doc/BRIEF.md
# Synchronous Burst Static RAM Model

This block is a synthesizable behavioural model of a flow-through synchronous burst static RAM. It holds a small, parameterised number of words, each split into four byte lanes of nine bits. On every rising clock edge it samples the address, the control pins and the write data. A burst opens on either of two start strobes, one for a processor and one for a cache controller. After that a 2-bit counter supplies the next three addresses, moving one step each cycle in which the step input is low. The low two address bits follow either a wrapping increment or an XOR pattern.

Writes take effect on the edge after the one that sampled them. Read data is combinational from the sampled address, so it appears in the same cycle. The single shared data bus is split into a write-data input and a read-data output, and a valid flag takes the place of the output drivers being enabled. A caller uses the block as a drop-in memory for a bus master that issues burst transfers of four words.

Top module: `sbsram_top`

## Requirements
- R1: While reset is held and in the cycles after it, `rvalid_o` is 0 and `rdata_o` is all zeros until a selected read has been sampled.
- R2: A processor start (`cpu_start_n` low with `en_a_n` low) sampled while all three enables are active (`en_a_n` low, `en_b` high, `en_c_n` low) loads the address and is a read in that cycle, whatever the write pins are. The stored word appears on `rdata_o` in the cycle that follows that edge.
- R3: A controller start (`ctl_start_n` low, no processor start) with all enables active loads the address. That cycle is a write if a write is requested and a read otherwise. A processor start wins over a controller start in the same cycle.
- R4: With `wr_all_n` low, every lane of the addressed word is written from `wdata_i`, whatever `wr_lanes_n` and `lane_n` are.
- R5: With `wr_all_n` high and `wr_lanes_n` low, only the lanes whose `lane_n[i]` bit is low are written. Lane i occupies data bits [9i+8:9i]. If no lane bit is low, the cycle is a read.
- R6: In linear order (`order_xor` low at burst start), the low two address bits are the start bits plus the count, modulo 4. A fifth step wraps back to the start address.
- R7: In XOR order (`order_xor` high at burst start), the low two address bits are the start bits XOR the count. The order is latched at burst start, and later changes of `order_xor` have no effect on the running burst.
- R8: With no start and `step_n` low, the count advances by one. With no start and `step_n` high, the same word is accessed again.
- R9: A start sampled while any of the three enables is inactive deselects the block from the next cycle on. A deselected block gives no read data and writes nothing.
- R10: A processor strobe sampled while `en_a_n` is high is ignored. The running burst holds or advances as if the strobe were absent.
- R11: `rvalid_o` is high only while `rd_oe_n` is low and the last sampled cycle was a selected read. Otherwise `rdata_o` is zero. `rd_oe_n` acts without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address sampled at a burst start |
| cpu_start_n | input | 1 | Processor burst start strobe, active low |
| ctl_start_n | input | 1 | Controller burst start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lanes_n | input | 1 | Per-lane write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b | input | 1 | Second chip enable, active high |
| en_c_n | input | 1 | Third chip enable, active low |
| rd_oe_n | input | 1 | Read output enable, active low |
| order_xor | input | 1 | Burst order: 0 linear, 1 XOR |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data is being presented |

## Verification
Each command is applied half a period before the edge that samples it and is judged 1 ns after that edge. At that point the registered address, the read/write decision and the flow-through read data all belong to the same command, so a read result is checked in the command's own cycle. A write is committed on the edge after it is sampled. It is therefore verified only by a later read, issued at least one cycle afterwards. Output-enable gating is combinational, so it is checked by toggling `rd_oe_n` between edges and sampling again with no edge in between.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  // Low two address bits for a given start and burst count
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORD_XOR) r = start ^ cnt;
    else                r = start + cnt;
    return r;
  endfunction

endpackage

// File: rtl/sbsram_addr_seq.sv
`timescale 1ns/1ps
module sbsram_addr_seq
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              order_in,
  output logic [ADDR_W-1:0] addr_eff
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  burst_order_e      ord_q, ord_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    ord_d  = ord_q;
    if (load) begin
      base_d = base_in;
      cnt_d  = 2'd0;
      ord_d  = burst_order_e'(order_in);
    end else if (step) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      ord_q  <= ORD_LINEAR;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ord_q  <= ord_d;
    end
  end

  assign addr_eff = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, ord_q)};

endmodule

// File: rtl/sbsram_cmd.sv
`timescale 1ns/1ps
module sbsram_cmd #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lanes_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  output logic             load,
  output logic             step,
  output logic             rd_q,
  output logic [LANES-1:0] mask_q
);

  logic             all_on, cpu_go, ctl_go, start;
  logic [LANES-1:0] lanes_req, mask_d;
  logic             active_q, active_d, rd_d;

  always_comb begin
    all_on    = !en_a_n && en_b && !en_c_n;
    cpu_go    = !cpu_start_n && !en_a_n;
    ctl_go    = !ctl_start_n && !cpu_go;
    start     = cpu_go || ctl_go;
    load      = start && all_on;
    step      = !start && !step_n;
    if (!wr_all_n)        lanes_req = '1;
    else if (!wr_lanes_n) lanes_req = ~lane_n;
    else                  lanes_req = '0;
    active_d  = start ? all_on : active_q;
    mask_d    = (active_d && !cpu_go) ? lanes_req : '0;
    rd_d      = active_d && (mask_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      mask_q   <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      mask_q   <= mask_d;
    end
  end

endmodule

// File: rtl/sbsram_store.sv
`timescale 1ns/1ps
module sbsram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata_in,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] wdata_q;

  // Write data sampled with the address; committed one edge later
  always_ff @(posedge clk) begin
    wdata_q <= wdata_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) begin
        cells[addr] <= wdata_q[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end

endmodule

// File: rtl/sbsram_top.sv
`timescale 1ns/1ps
module sbsram_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cpu_start_n,
  input  logic                    ctl_start_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lanes_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    rd_oe_n,
  input  logic                    order_xor,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              load, step, rd_q;
  logic [LANES-1:0]  mask_q;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] store_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sbsram_cmd #(.LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_core_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lanes_n(wr_lanes_n), .lane_n(lane_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .load(load), .step(step), .rd_q(rd_q), .mask_q(mask_q)
  );

  sbsram_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .load(load), .step(step),
    .base_in(addr_i), .order_in(order_xor), .addr_eff(addr_eff)
  );

  sbsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .wr_mask(mask_q), .addr(addr_eff),
    .wdata_in(wdata_i), .rdata(store_rd)
  );

  assign rvalid_o = rd_q && !rd_oe_n;
  assign rdata_o  = rvalid_o ? store_rd : '0;

endmodule

// File: rtl/sbsram_chk.sv
`timescale 1ns/1ps
module sbsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_start_n,
  input logic              ctl_start_n,
  input logic              step_n,
  input logic              wr_all_n,
  input logic              wr_lanes_n,
  input logic              en_a_n,
  input logic              en_b,
  input logic              en_c_n,
  input logic              rd_oe_n,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);

  logic all_on;
  assign all_on = !en_a_n && en_b && !en_c_n;

  // R2: processor start with all enables is a read in the next cycle
  p_cpu_start_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_n && all_on) |=> (rd_oe_n || rvalid_o));

  // R4: a global write at controller start never presents read data
  p_global_write_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_n && !ctl_start_n && all_on && !wr_all_n) |=> !rvalid_o);

  // R8: holding with no write keeps the presented word unchanged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && cpu_start_n && ctl_start_n && step_n && wr_all_n && wr_lanes_n)
    |=> (rd_oe_n || $stable(rdata_o)));

  // R9: a start with an inactive enable deselects within one cycle
  p_deselect_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctl_start_n || (!cpu_start_n && !en_a_n)) && !all_on) |=> !rvalid_o);

  // R10: processor strobe with primary enable off does not disturb a held read
  p_cpu_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && !cpu_start_n && en_a_n && ctl_start_n && step_n && wr_all_n && wr_lanes_n)
    |=> (rd_oe_n || $stable(rdata_o)));

endmodule

bind sbsram_top sbsram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
  .wr_all_n(wr_all_n), .wr_lanes_n(wr_lanes_n),
  .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .rd_oe_n(rd_oe_n),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/tb_sbsram_top.sv
`timescale 1ns/1ps
module tb_sbsram_top;

  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          cpu_start_n, ctl_start_n, step_n, wr_all_n, wr_lanes_n;
  logic [LN-1:0] lane_n;
  logic          en_a_n, en_b, en_c_n, rd_oe_n, order_xor;
  logic [DW-1:0] wdata_i, rdata_o;
  logic          rvalid_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  sbsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lanes_n(wr_lanes_n), .lane_n(lane_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .rd_oe_n(rd_oe_n),
    .order_xor(order_xor), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 36'h1_0203_0405) ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic expect_out(input string req, input logic v, input logic [DW-1:0] d);
    n_chk++;
    if (rvalid_o !== v || rdata_o !== d) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               req, rvalid_o, rdata_o, v, d);
    end
  endtask

  // Apply one command before an edge, return 1 ns after it
  task automatic issue(input logic cpu, input logic ctl, input logic adv,
                       input logic [AW-1:0] a, input logic gw, input logic bw,
                       input logic [LN-1:0] sel_n, input logic [DW-1:0] d,
                       input logic oe_off);
    @(negedge clk);
    cpu_start_n = !cpu; ctl_start_n = !ctl; step_n = !adv;
    addr_i = a; wr_all_n = !gw; wr_lanes_n = !bw; lane_n = sel_n;
    wdata_i = d; rd_oe_n = oe_off;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    issue(0, 0, 0, '0, 0, 0, '1, '0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cpu_start_n = 1; ctl_start_n = 1; step_n = 1; wr_all_n = 1; wr_lanes_n = 1;
    lane_n = '1; en_a_n = 0; en_b = 1; en_c_n = 0; rd_oe_n = 0; order_xor = 0;
    addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 expect_out("R1 in reset", 0, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 expect_out("R1 after reset", 0, '0);
  endtask

  // Global-write bursts of four words fill the whole array (R3, R4, R6)
  task automatic t_fill();
    for (int b = 0; b < DEPTH / 4; b++) begin
      issue(0, 1, 0, AW'(4 * b), 1, 0, '1, pat(4 * b), 0);
      model[4 * b] = pat(4 * b);
      if (b == 0) expect_out("R3 write cycle gives no read", 0, '0);
      for (int k = 1; k < 4; k++) begin
        issue(0, 0, 1, '0, 1, 0, '1, pat(4 * b + k), 0);
        model[4 * b + k] = pat(4 * b + k);
      end
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      issue(1, 0, 0, AW'(a), 0, 0, '1, '0, 0);
      expect_out("R2 read after fill", 1, model[a]);
    end
  endtask

  task automatic t_cpu_write_pins();
    issue(1, 0, 0, 6'd17, 1, 1, '0, 36'hF_FFFF_FFFF, 0);
    expect_out("R2 cpu start reads despite write pins", 1, model[17]);
    idle();
    expect_out("R2 no write on cpu start", 1, model[17]);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d;
    d = 36'h1_2345_6789;
    issue(0, 1, 0, 6'd5, 0, 1, 4'b1010, d, 0);
    model[5][0 +: LW]    = d[0 +: LW];
    model[5][2*LW +: LW] = d[2*LW +: LW];
    issue(1, 0, 0, 6'd5, 0, 0, '1, '0, 0);
    expect_out("R5 lanes 0 and 2 only", 1, model[5]);
    issue(0, 1, 0, 6'd6, 0, 1, 4'b1111, d, 0);
    expect_out("R5 no lane selected reads", 1, model[6]);
    d = 36'h9_8765_4321;
    issue(0, 1, 0, 6'd7, 1, 1, 4'b1111, d, 0);
    model[7] = d;
    issue(1, 0, 0, 6'd7, 0, 0, '1, '0, 0);
    expect_out("R4 global write overrides lanes", 1, model[7]);
  endtask

  task automatic t_ctl_read();
    issue(0, 1, 0, 6'd33, 0, 0, '1, '0, 0);
    expect_out("R3 controller start read", 1, model[33]);
    issue(1, 1, 0, 6'd34, 1, 0, '1, 36'h0_0000_0001, 0);
    expect_out("R3 cpu start wins over controller", 1, model[34]);
    idle();
    expect_out("R3 no write when cpu wins", 1, model[34]);
  endtask

  task automatic t_linear();
    int seq [5] = '{6, 7, 4, 5, 6};
    order_xor = 0;
    issue(1, 0, 0, 6'd6, 0, 0, '1, '0, 0);
    expect_out("R6 linear start", 1, model[6]);
    for (int k = 1; k < 5; k++) begin
      issue(0, 0, 1, '0, 0, 0, '1, '0, 0);
      expect_out("R6 linear step/wrap", 1, model[seq[k]]);
    end
  endtask

  task automatic t_xor();
    int seq [4] = '{9, 8, 11, 10};
    order_xor = 1;
    issue(1, 0, 0, 6'd9, 0, 0, '1, '0, 0);
    expect_out("R7 xor start", 1, model[9]);
    order_xor = 0;
    for (int k = 1; k < 4; k++) begin
      issue(0, 0, 1, '0, 0, 0, '1, '0, 0);
      expect_out("R7 xor step, order latched", 1, model[seq[k]]);
    end
  endtask

  task automatic t_hold();
    issue(1, 0, 0, 6'd12, 0, 0, '1, '0, 0);
    expect_out("R8 start", 1, model[12]);
    idle();
    expect_out("R8 hold 1", 1, model[12]);
    idle();
    expect_out("R8 hold 2", 1, model[12]);
    issue(0, 0, 1, '0, 0, 0, '1, '0, 0);
    expect_out("R8 advance", 1, model[13]);
  endtask

  task automatic t_deselect();
    en_c_n = 1;
    issue(0, 1, 0, 6'd20, 1, 0, '1, 36'h0_DEAD_BEEF, 0);
    expect_out("R9 controller start deselected", 0, '0);
    issue(0, 0, 1, '0, 1, 0, '1, 36'h0_DEAD_BEEF, 0);
    expect_out("R9 stays deselected", 0, '0);
    en_c_n = 0; en_b = 0;
    issue(1, 0, 0, 6'd21, 0, 0, '1, '0, 0);
    expect_out("R9 cpu start deselected", 0, '0);
    en_b = 1;
    issue(1, 0, 0, 6'd20, 0, 0, '1, '0, 0);
    expect_out("R9 no write while deselected", 1, model[20]);
  endtask

  task automatic t_cpu_ignored();
    issue(1, 0, 0, 6'd24, 0, 0, '1, '0, 0);
    expect_out("R10 start", 1, model[24]);
    en_a_n = 1;
    issue(1, 0, 0, 6'd40, 0, 0, '1, '0, 0);
    expect_out("R10 strobe ignored, hold", 1, model[24]);
    en_a_n = 0;
    issue(0, 0, 1, '0, 0, 0, '1, '0, 0);
    expect_out("R10 burst continues", 1, model[25]);
  endtask

  task automatic t_oe();
    issue(1, 0, 0, 6'd3, 0, 0, '1, '0, 1);
    expect_out("R11 output disabled", 0, '0);
    rd_oe_n = 0; #1;
    expect_out("R11 enable without edge", 1, model[3]);
    issue(0, 1, 0, 6'd3, 1, 0, '1, model[3], 0);
    expect_out("R11 write cycle no data", 0, '0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_cpu_write_pins();
    t_lanes();
    t_ctl_read();
    t_linear();
    t_xor();
    t_hold();
    t_deselect();
    t_cpu_ignored();
    t_oe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule